// File: doc/BRIEF.md
# Segmented Firmware Image Checker

This block accepts a firmware image as a byte stream and validates its layout as the bytes arrive. The image opens with an 8-byte header made of an identification byte, a segment count, two ignored bytes and a little-endian entry address. Each segment follows, made of a little-endian load address, a little-endian byte count and that many data bytes. Zero fill then runs up to a trailing check byte, which must fall at a file length that is a multiple of 16.

Each segment data byte is sent out in the cycle after it is accepted, paired with its destination address. A loader placed downstream can write these bytes to memory. Once the image is complete or has failed, the block raises a one-cycle `done` pulse together with a pass flag, a reason code and the decoded entry address. The producer uses `in_last` to mark the final byte of every image. After an error that comes before the final byte, the block drops all input until `in_last` arrives, then waits for a new image.

Top module: `fw_image_checker`

## Requirements
- R1: After reset `out_valid`, `done`, `pass` and `err_code` are all zero.
- R2: If the first byte of an image is not 0xE9, `done` rises one cycle later with `err_code` 1 and `pass` low. Every following byte up to and including the one flagged `in_last` is dropped: no data output and no further `done`.
- R3: Byte 1 is the segment count and bytes 2 and 3 are ignored. Bytes 4 to 7 form the entry address, least significant byte first, and it shows on `entry_point` when `done` reports a pass.
- R4: A segment header holds a 4-byte load address and then a 4-byte size, each least significant byte first. Each data byte appears on `out_data` one cycle after it is accepted, with `out_valid` high and `out_addr` equal to the load address plus the byte's offset within the segment.
- R5: A segment of size 0 emits nothing and is followed directly by the next segment header, or by padding if it was the last segment. A count of 0 goes straight to padding.
- R6: The final byte is compared with the XOR of 0xEF and every segment data byte. Header and segment-header bytes are excluded. A mismatch reports `err_code` 3.
- R7: Every byte between the last segment and the final byte must be 0x00. The first non-zero one reports `err_code` 2 one cycle after it is accepted.
- R8: The final byte must be the byte at a file offset of 15 mod 16. It must also carry `in_last`. If `in_last` comes earlier in the padding, or the byte at offset 15 mod 16 lacks `in_last`, the block reports `err_code` 5.
- R9: If `in_last` arrives while the header, a segment header or segment data is still incomplete, the block reports `err_code` 4 and does not emit that byte as data.
- R10: A valid image gives `done` high with `pass` high and `err_code` 0 one cycle after its final byte. Cycles with `in_valid` low leave all parsing state unchanged. The byte after a finished image starts a new image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is present this cycle |
| in_byte | input | 8 | Image byte |
| in_last | input | 1 | Marks the final byte of the image |
| out_valid | output | 1 | Segment data byte present |
| out_addr | output | 32 | Destination address of the data byte |
| out_data | output | 8 | Segment data byte |
| done | output | 1 | One-cycle pulse when an image is finished or rejected |
| pass | output | 1 | Image valid, meaningful with `done` |
| err_code | output | 3 | 0 ok, 1 id byte, 2 padding, 3 checksum, 4 truncated, 5 length |
| entry_point | output | 32 | Decoded entry address |

## Verification
Suppose the byte-position or segment bookkeeping slips by one. A data byte would then show up at the wrong address, or a header byte would leak onto `out_data`. The address scoreboard would catch either one in the very next output cycle. A fault in the running XOR or in the position-within-16 counter shows nothing until the image ends, where it turns a valid image into `err_code` 3 or 5, or gives the wrong code for a short or overlong image. A drain state that is left too soon would produce a spurious `done` or spurious data from the bytes it should drop.

// File: rtl/fw_image_checker.sv
module fw_image_checker #(
  parameter int          FIELD_BYTES = 4,
  parameter int          BLOCK       = 16,
  parameter logic [7:0]  MAGIC       = 8'hE9,
  parameter logic [7:0]  SEED        = 8'hEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [7:0]               in_byte,
  input  logic                     in_last,
  output logic                     out_valid,
  output logic [8*FIELD_BYTES-1:0] out_addr,
  output logic [7:0]               out_data,
  output logic                     done,
  output logic                     pass,
  output logic [2:0]               err_code,
  output logic [8*FIELD_BYTES-1:0] entry_point
);
  localparam int FW       = 8 * FIELD_BYTES;
  localparam int HDR_LEN  = 4 + FIELD_BYTES;
  localparam int SHDR_LEN = 2 * FIELD_BYTES;
  localparam int IDX_W    = $clog2(SHDR_LEN > HDR_LEN ? SHDR_LEN : HDR_LEN) + 1;
  localparam int PH_W     = $clog2(BLOCK);

  localparam logic [2:0] E_NONE  = 3'd0;
  localparam logic [2:0] E_MAGIC = 3'd1;
  localparam logic [2:0] E_PAD   = 3'd2;
  localparam logic [2:0] E_CSUM  = 3'd3;
  localparam logic [2:0] E_TRUNC = 3'd4;
  localparam logic [2:0] E_LEN   = 3'd5;

  typedef enum logic [2:0] {S_HDR, S_SHDR, S_DATA, S_PAD, S_DRAIN} state_t;

  state_t           state, st_n;
  logic [IDX_W-1:0] idx, idx_n;
  logic [7:0]       segs, segs_n;
  logic [FW-1:0]    cur_addr, addr_n;
  logic [FW-1:0]    remain, rem_n;
  logic [PH_W-1:0]  phase, ph_n;
  logic [7:0]       csum, cs_n;
  logic [FW-1:0]    ent_n;
  logic             ov_n;
  logic [FW-1:0]    oa_n;
  logic [7:0]       od_n;
  logic             fin;
  logic [2:0]       code;

  wire [FW-1:0] len_next  = {in_byte, remain[FW-1:8]};
  wire          hdr_end   = idx == IDX_W'(HDR_LEN - 1);
  wire          shdr_end  = idx == IDX_W'(SHDR_LEN - 1);
  wire          last_seg  = segs == 8'd1;
  wire          blk_end   = phase == PH_W'(BLOCK - 1);

  always_comb begin
    st_n   = state;
    idx_n  = idx;
    segs_n = segs;
    addr_n = cur_addr;
    rem_n  = remain;
    ph_n   = phase;
    cs_n   = csum;
    ent_n  = entry_point;
    ov_n   = 1'b0;
    oa_n   = out_addr;
    od_n   = out_data;
    fin    = 1'b0;
    code   = E_NONE;
    if (in_valid) begin
      ph_n = phase + 1'b1;
      case (state)
        S_HDR: begin
          idx_n = idx + 1'b1;
          if (idx == '0 && in_byte != MAGIC) begin
            fin  = 1'b1;
            code = E_MAGIC;
          end else if (in_last) begin
            fin  = 1'b1;
            code = E_TRUNC;
          end else begin
            if (idx == IDX_W'(1)) segs_n = in_byte;
            if (idx >= IDX_W'(4)) ent_n = {in_byte, entry_point[FW-1:8]};
            if (hdr_end) begin
              idx_n = '0;
              st_n  = (segs == 8'd0) ? S_PAD : S_SHDR;
            end
          end
        end
        S_SHDR: begin
          if (in_last) begin
            fin  = 1'b1;
            code = E_TRUNC;
          end else begin
            idx_n = idx + 1'b1;
            if (idx < IDX_W'(FIELD_BYTES)) addr_n = {in_byte, cur_addr[FW-1:8]};
            else                           rem_n  = len_next;
            if (shdr_end) begin
              idx_n = '0;
              if (len_next == '0) begin
                segs_n = segs - 1'b1;
                st_n   = last_seg ? S_PAD : S_SHDR;
              end else begin
                st_n = S_DATA;
              end
            end
          end
        end
        S_DATA: begin
          if (in_last) begin
            fin  = 1'b1;
            code = E_TRUNC;
          end else begin
            ov_n   = 1'b1;
            oa_n   = cur_addr;
            od_n   = in_byte;
            addr_n = cur_addr + 1'b1;
            rem_n  = remain - 1'b1;
            cs_n   = csum ^ in_byte;
            if (remain == FW'(1)) begin
              segs_n = segs - 1'b1;
              st_n   = last_seg ? S_PAD : S_SHDR;
            end
          end
        end
        S_PAD: begin
          if (blk_end) begin
            fin  = 1'b1;
            code = !in_last ? E_LEN : (csum == in_byte ? E_NONE : E_CSUM);
          end else if (in_last) begin
            fin  = 1'b1;
            code = E_LEN;
          end else if (in_byte != 8'h00) begin
            fin  = 1'b1;
            code = E_PAD;
          end
        end
        default: begin
          if (in_last) st_n = S_HDR;
        end
      endcase
      if (fin || (state == S_DRAIN && in_last)) begin
        idx_n = '0;
        ph_n  = '0;
        cs_n  = SEED;
      end
      if (fin) st_n = in_last ? S_HDR : S_DRAIN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_HDR;
      idx         <= '0;
      segs        <= '0;
      cur_addr    <= '0;
      remain      <= '0;
      phase       <= '0;
      csum        <= SEED;
      entry_point <= '0;
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_data    <= '0;
      done        <= 1'b0;
      pass        <= 1'b0;
      err_code    <= E_NONE;
    end else begin
      state       <= st_n;
      idx         <= idx_n;
      segs        <= segs_n;
      cur_addr    <= addr_n;
      remain      <= rem_n;
      phase       <= ph_n;
      csum        <= cs_n;
      entry_point <= ent_n;
      out_valid   <= ov_n;
      out_addr    <= oa_n;
      out_data    <= od_n;
      done        <= fin;
      if (fin) begin
        pass     <= code == E_NONE;
        err_code <= code;
      end
    end
  end

  // R4
  data_from_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && !in_last));

  // R9
  no_data_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && done));

  // R10
  pass_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> $past(in_valid && in_last));

  // R8
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> err_code <= 3'd5);

  // R2
  magic_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 3'd1) |-> $past(state == S_HDR && idx == '0));
endmodule

// File: tb/fw_image_checker_tb.sv
module fw_image_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic [7:0]  out_data;
  logic        done;
  logic        pass;
  logic [2:0]  err_code;
  logic [31:0] entry_point;

  always #4 clk = ~clk;

  fw_image_checker u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .out_valid(out_valid), .out_addr(out_addr),
    .out_data(out_data), .done(done), .pass(pass), .err_code(err_code),
    .entry_point(entry_point)
  );

  int checks = 0;
  int fails  = 0;
  logic [8:0]  img[$];
  logic [39:0] exp_q[$];
  logic [34:0] res_q[$];
  string       req_q[$];
  logic [7:0]  run_cs;
  bit          emit;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [39:0] act, input logic [39:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic pb(input logic [7:0] b, input bit last = 1'b0);
    img.push_back({last, b});
  endtask

  task automatic hdr(input logic [7:0] mg, input logic [7:0] cnt, input logic [31:0] ent);
    run_cs = 8'hEF;
    pb(mg); pb(cnt); pb(8'hA5); pb(8'h5A);
    for (int i = 0; i < 4; i++) pb(ent[8*i +: 8]);
  endtask

  task automatic seg(input logic [31:0] a, input int len, input logic [7:0] seed);
    for (int i = 0; i < 4; i++) pb(a[8*i +: 8]);
    for (int i = 0; i < 4; i++) pb(8'(len >> (8*i)));
    for (int i = 0; i < len; i++) begin
      logic [7:0] d;
      d = seed + 8'(i * 7);
      pb(d);
      run_cs ^= d;
      if (emit) exp_q.push_back({a + 32'(i), d});
    end
  endtask

  task automatic tail(input int bad_at, input logic [7:0] flip);
    int n = 0;
    while (img.size() % 16 != 15) begin
      pb(n == bad_at ? 8'h3C : 8'h00);
      n++;
    end
    pb(run_cs ^ flip, 1'b1);
  endtask

  task automatic expect_res(input logic [2:0] c, input logic [31:0] e, input string r);
    res_q.push_back({c, e});
    req_q.push_back(r);
  endtask

  task automatic send(input bit gaps);
    for (int i = 0; i < img.size(); i++) begin
      if (gaps && i % 3 == 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'hFF;
        in_last  = 1'b1;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = img[i][7:0];
      in_last  = img[i][8];
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    repeat (3) @(negedge clk);
    img.delete();
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected data", {out_addr, out_data}, 40'h0);
        end else begin
          logic [39:0] e;
          e = exp_q.pop_front();
          check({out_addr, out_data} == e, "R4", "data/address", {out_addr, out_data}, e);
        end
      end
      if (done) begin
        if (res_q.size() == 0) begin
          check(1'b0, "R10", "unexpected done", 40'(err_code), 40'h0);
        end else begin
          logic [34:0] r;
          string rq;
          r  = res_q.pop_front();
          rq = req_q.pop_front();
          check(err_code == r[34:32], rq, "err_code", 40'(err_code), 40'(r[34:32]));
          check(pass == (r[34:32] == 3'd0), rq, "pass", 40'(pass), 40'(r[34:32] == 3'd0));
          if (r[34:32] == 3'd0)
            check(entry_point == r[31:0], "R3", "entry_point", 40'(entry_point), 40'(r[31:0]));
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    emit = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check({out_valid, done, pass, err_code} == 6'd0, "R1", "reset outputs",
          40'({out_valid, done, pass, err_code}), 40'h0);

    // R3 R4 R6 R10: valid two-segment image
    hdr(8'hE9, 8'd2, 32'h4010_0004);
    seg(32'h4010_0000, 5, 8'h11);
    seg(32'h3FFE_8000, 3, 8'h90);
    tail(-1, 8'h00);
    expect_res(3'd0, 32'h4010_0004, "R10");
    send(1'b0);

    // R10 with idle gaps mid-stream
    hdr(8'hE9, 8'd1, 32'h1234_5678);
    seg(32'h0000_0FFE, 4, 8'hF0);
    tail(-1, 8'h00);
    expect_res(3'd0, 32'h1234_5678, "R10");
    send(1'b1);

    // R5: zero count
    hdr(8'hE9, 8'd0, 32'hCAFE_0001);
    tail(-1, 8'h00);
    expect_res(3'd0, 32'hCAFE_0001, "R5");
    send(1'b0);

    // R5: zero-size segments around a real one
    hdr(8'hE9, 8'd3, 32'h0000_0100);
    seg(32'h2000_0000, 0, 8'h00);
    seg(32'h2000_0040, 4, 8'h33);
    seg(32'h2000_0080, 0, 8'h00);
    tail(-1, 8'h00);
    expect_res(3'd0, 32'h0000_0100, "R5");
    send(1'b0);

    // R2: bad magic, rest drained
    emit = 1'b0;
    hdr(8'hE8, 8'd1, 32'h0);
    seg(32'h5000_0000, 6, 8'h01);
    tail(-1, 8'h00);
    expect_res(3'd1, 32'h0, "R2");
    send(1'b0);
    emit = 1'b1;

    // R7: non-zero padding byte
    hdr(8'hE9, 8'd1, 32'h0);
    seg(32'h6000_0000, 2, 8'h44);
    tail(3, 8'h00);
    expect_res(3'd2, 32'h0, "R7");
    send(1'b0);

    // R6: checksum mismatch
    hdr(8'hE9, 8'd1, 32'h0);
    seg(32'h7000_0000, 9, 8'h21);
    tail(-1, 8'h01);
    expect_res(3'd3, 32'h0, "R6");
    send(1'b0);

    // R9: final byte inside segment data, that byte not emitted
    hdr(8'hE9, 8'd1, 32'h0);
    seg(32'h8000_0000, 3, 8'h07);
    img[img.size()-1][8] = 1'b1;
    void'(exp_q.pop_back());
    expect_res(3'd4, 32'h0, "R9");
    send(1'b0);

    // R9: final byte inside a segment header
    hdr(8'hE9, 8'd1, 32'h0);
    pb(8'h00); pb(8'h10, 1'b1);
    expect_res(3'd4, 32'h0, "R9");
    send(1'b0);

    // R8: in_last early in padding
    hdr(8'hE9, 8'd1, 32'h0);
    seg(32'h9000_0000, 2, 8'h50);
    while (img.size() % 16 != 9) pb(8'h00);
    pb(8'h00, 1'b1);
    expect_res(3'd5, 32'h0, "R8");
    send(1'b0);

    // R8: checksum position without in_last, extra byte drained
    hdr(8'hE9, 8'd1, 32'h0);
    seg(32'hA000_0000, 2, 8'h60);
    tail(-1, 8'h00);
    img[img.size()-1][8] = 1'b0;
    pb(8'h00, 1'b1);
    expect_res(3'd5, 32'h0, "R8");
    send(1'b0);

    // R10: recovery after errors
    hdr(8'hE9, 8'd1, 32'hBEEF_0002);
    seg(32'hB000_0010, 1, 8'h77);
    tail(-1, 8'h00);
    expect_res(3'd0, 32'hBEEF_0002, "R10");
    send(1'b0);

    check(exp_q.size() == 0, "R4", "missing data items", 40'(exp_q.size()), 40'h0);
    check(res_q.size() == 0, "R10", "missing done pulses", 40'(res_q.size()), 40'h0);
    summary();
  end
endmodule